// File: doc/BRIEF.md
# SHA-256 Block Compression Engine

This block runs the SHA-256 compression function over one 512-bit message block. It executes one round per clock for 64 rounds, and expands the message schedule on the fly in a rolling ring of sixteen 32-bit words. It takes each round constant from a combinational table indexed by the round counter. An enclosing controller pads the message, groups its bytes into blocks and sequences the blocks. For each block it presents the block, a chaining value and a first-block flag, then pulses start.

When the first-block flag is high, the working variables begin from the standard SHA-256 initial hash words. Otherwise they begin from the supplied chaining value. After the last round each working variable is added modulo 2^32 to its starting word. The eight sums appear on the hash output and the ready flag rises.

The controller is a three-state machine. IDLE waits for start. START_ACCEPT moves it from IDLE or DONE into RUN. RUN counts rounds 0 to 63, and LAST_ROUND moves it from RUN into DONE. DONE holds the result until the next start. A start seen in RUN is ignored.

Top module: `sha256_compress`

## Requirements
- R1: After a synchronous active-high reset, ready_o is 0 and hash_o is all zeros.
- R2: When start_i is accepted at a rising edge, ready_o is 0 after each of the following 63 edges and becomes 1 after the 64th edge.
- R3: With first_i = 1 the result uses the standard initial hash words. The block {61626380h, fourteen zero words, 00000018h} yields ba7816bf…f20015ad. An all-zero block except word 0 = 80000000h yields e3b0c442…7852b855.
- R4: With first_i = 0 the result starts from chain_i. Chaining two blocks of the 56-byte message "abcdbcde…nopq" yields 248d6a61…19db06c1.
- R5: Block word 0 is block_i[511:480] (big-endian words). H0 is hash_o[255:224] and H7 is hash_o[31:0]. The result for any block and chaining value equals the SHA-256 compression function.
- R6: A start_i pulse while a block is running is ignored: neither the timing nor the result of the running block changes.
- R7: Once ready_o is 1, it and hash_o stay unchanged until the next start_i is accepted, whatever the other inputs do.
- R8: A start_i while ready_o is 1 is accepted: ready_o is 0 after the next edge.
- R9: block_i, chain_i and first_i are sampled only at the accepting edge. Changing them during a run does not affect the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; accepted when not running |
| first_i | input | 1 | 1: start from the standard initial words; 0: start from chain_i |
| block_i | input | 512 | Message block, word 0 in bits 511:480 |
| chain_i | input | 256 | Chaining value from the previous block, H0 in bits 255:224 |
| hash_o | output | 256 | Updated hash state, H0 in bits 255:224 |
| ready_o | output | 1 | High from completion until the next accepted start |

## Verification
Every result is timed from the edge that accepts start_i. ready_o must fall one edge later (if it was high) and must rise, with the new hash_o, exactly 64 edges later. The bench counts edges from the accepting edge and samples on the falling edge after edge 63 (ready still low) and after edge 64 (ready high, digest compared). Runs that inject a stray start or scramble the inputs mid-run keep the same count, so any shift in timing or result shows up at those two sample points.

// File: rtl/sha256_pkg.sv
package sha256_pkg;

    localparam int WORD_W   = 32;
    localparam int N_SCHED  = 16;
    localparam int N_VARS   = 8;
    localparam int N_ROUNDS = 64;
    localparam int BLOCK_W  = WORD_W * N_SCHED;
    localparam int STATE_W  = WORD_W * N_VARS;
    localparam int RND_W    = $clog2(N_ROUNDS);
    localparam int SCH_W    = $clog2(N_SCHED);

    typedef logic [WORD_W-1:0] word_t;

    // index N_VARS-1 holds H0 (most significant word)
    typedef logic [N_VARS-1:0][WORD_W-1:0] hstate_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
        word_t e;
        word_t f;
        word_t g;
        word_t h;
    } wvars_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } eng_state_e;

    function automatic word_t rotr(input word_t x, input int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t big_sig0(input word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t big_sig1(input word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t sml_sig0(input word_t x);
        return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
    endfunction

    function automatic word_t sml_sig1(input word_t x);
        return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
    endfunction

    function automatic word_t choose(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (~x & z);
    endfunction

    function automatic word_t majority(input word_t x, input word_t y, input word_t z);
        return (x & y) ^ (x & z) ^ (y & z);
    endfunction

    function automatic hstate_t std_init();
        hstate_t r;
        r[7] = 32'h6a09e667;
        r[6] = 32'hbb67ae85;
        r[5] = 32'h3c6ef372;
        r[4] = 32'ha54ff53a;
        r[3] = 32'h510e527f;
        r[2] = 32'h9b05688c;
        r[1] = 32'h1f83d9ab;
        r[0] = 32'h5be0cd19;
        return r;
    endfunction

endpackage

// File: rtl/sha_kconst.sv
module sha_kconst
    import sha256_pkg::*;
(
    input  logic [RND_W-1:0] idx_i,
    output word_t            k_o
);

    localparam word_t KTAB [0:N_ROUNDS-1] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
        32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
        32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
        32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
        32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
        32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
        32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
        32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
        32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    assign k_o = KTAB[idx_i];

endmodule

// File: rtl/sha_msg_sched.sv
module sha_msg_sched
    import sha256_pkg::*;
(
    input  logic                clk,
    input  logic                load_i,
    input  logic [BLOCK_W-1:0]  block_i,
    input  logic                step_i,
    input  logic [RND_W-1:0]    rnd_i,
    output word_t               w_o
);

    word_t            wring [N_SCHED];
    logic [SCH_W-1:0] slot;
    logic [SCH_W-1:0] slot_m2;
    logic [SCH_W-1:0] slot_m7;
    logic [SCH_W-1:0] slot_m15;
    word_t            expanded;

    assign slot     = rnd_i[SCH_W-1:0];
    assign slot_m2  = slot - SCH_W'(2);
    assign slot_m7  = slot - SCH_W'(7);
    assign slot_m15 = slot - SCH_W'(15);

    always_comb begin
        expanded = sml_sig1(wring[slot_m2]) + wring[slot_m7]
                 + sml_sig0(wring[slot_m15]) + wring[slot];
        if (int'(rnd_i) < N_SCHED)
            w_o = wring[slot];
        else
            w_o = expanded;
    end

    generate
        for (genvar i = 0; i < N_SCHED; i++) begin : g_lane
            always_ff @(posedge clk) begin
                if (load_i)
                    wring[i] <= block_i[BLOCK_W-1-i*WORD_W -: WORD_W];
                else if (step_i && slot == SCH_W'(i))
                    wring[i] <= w_o;
            end
        end
    endgenerate

endmodule

// File: rtl/sha_round.sv
module sha_round
    import sha256_pkg::*;
(
    input  wvars_t v_i,
    input  word_t  k_i,
    input  word_t  w_i,
    output wvars_t v_o
);

    word_t t1;
    word_t t2;

    always_comb begin
        t1 = v_i.h + big_sig1(v_i.e) + choose(v_i.e, v_i.f, v_i.g) + k_i + w_i;
        t2 = big_sig0(v_i.a) + majority(v_i.a, v_i.b, v_i.c);
        v_o.a = t1 + t2;
        v_o.b = v_i.a;
        v_o.c = v_i.b;
        v_o.d = v_i.c;
        v_o.e = v_i.d + t1;
        v_o.f = v_i.e;
        v_o.g = v_i.f;
        v_o.h = v_i.g;
    end

endmodule

// File: rtl/sha256_compress.sv
module sha256_compress
    import sha256_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               first_i,
    input  logic [BLOCK_W-1:0] block_i,
    input  logic [STATE_W-1:0] chain_i,
    output logic [STATE_W-1:0] hash_o,
    output logic               ready_o
);

    eng_state_e       state_q;
    eng_state_e       state_d;
    logic [RND_W-1:0] rnd_q;
    logic             accept;
    logic             last_rnd;
    logic             running;
    wvars_t           vars_q;
    wvars_t           vars_nxt;
    hstate_t          seed_q;
    hstate_t          seed_sel;
    hstate_t          nxt_h;
    hstate_t          sum_h;
    hstate_t          hash_q;
    word_t            k_cur;
    word_t            w_cur;

    assign accept   = start_i && (state_q != ST_RUN);
    assign last_rnd = (rnd_q == RND_W'(N_ROUNDS - 1));
    assign seed_sel = first_i ? std_init() : hstate_t'(chain_i);

    // next-state logic: START_ACCEPT and LAST_ROUND transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)   state_d = ST_RUN;
            ST_RUN:  if (last_rnd) state_d = ST_DONE;
            ST_DONE: if (accept)   state_d = ST_RUN;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_comb begin
        ready_o = (state_q == ST_DONE);
        running = (state_q == ST_RUN);
        hash_o  = hash_q;
    end

    sha_kconst u_kconst (
        .idx_i (rnd_q),
        .k_o   (k_cur)
    );

    sha_msg_sched u_sched (
        .clk     (clk),
        .load_i  (accept),
        .block_i (block_i),
        .step_i  (running),
        .rnd_i   (rnd_q),
        .w_o     (w_cur)
    );

    sha_round u_round (
        .v_i (vars_q),
        .k_i (k_cur),
        .w_i (w_cur),
        .v_o (vars_nxt)
    );

    assign nxt_h = hstate_t'(vars_nxt);

    generate
        for (genvar i = 0; i < N_VARS; i++) begin : g_fold
            assign sum_h[i] = seed_q[i] + nxt_h[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rnd_q  <= '0;
            vars_q <= '0;
            seed_q <= '0;
            hash_q <= '0;
        end else if (accept) begin
            rnd_q  <= '0;
            vars_q <= wvars_t'(seed_sel);
            seed_q <= seed_sel;
        end else if (running) begin
            rnd_q  <= rnd_q + RND_W'(1);
            vars_q <= vars_nxt;
            if (last_rnd)
                hash_q <= sum_h;
        end
    end

endmodule

// File: rtl/sha256_compress_chk.sv
module sha256_compress_chk
    import sha256_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic               running,
    input logic               ready_o,
    input logic [STATE_W-1:0] hash_o
);

    logic [RND_W:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start_i && !running)
            cnt_q <= '0;
        else if (running)
            cnt_q <= cnt_q + (RND_W+1)'(1);
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !ready_o && hash_o == '0);

    assert_done_at_64_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> cnt_q == (RND_W+1)'(N_ROUNDS));

    assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
        running && start_i && cnt_q < (RND_W+1)'(N_ROUNDS - 1) |=> running);

    assert_ready_holds_R7: assert property (@(posedge clk) disable iff (rst)
        ready_o && !start_i |=> ready_o);

    assert_hash_stable_R7: assert property (@(posedge clk) disable iff (rst)
        ready_o && !$rose(ready_o) |-> $stable(hash_o));

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ready_o) |-> $past(start_i));

    assert_not_both_R2: assert property (@(posedge clk) disable iff (rst)
        !(ready_o && running));

endmodule

bind sha256_compress sha256_compress_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .running (running),
    .ready_o (ready_o),
    .hash_o  (hash_o)
);

// File: tb/tb_sha256_compress.sv
`timescale 1ns/1ps
module tb_sha256_compress;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         first_i = 1'b0;
    logic [511:0] block_i = '0;
    logic [255:0] chain_i = '0;
    logic [255:0] hash_o;
    logic         ready_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [31:0] kt  [64];
    logic [31:0] ivt [8];

    always #2.5 clk = ~clk;

    sha256_compress dut (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .first_i (first_i),
        .block_i (block_i),
        .chain_i (chain_i),
        .hash_o  (hash_o),
        .ready_o (ready_o)
    );

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rr(input logic [31:0] x, input int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    // constants from fractional parts of square and cube roots of primes
    task automatic build_consts();
        int primes [64];
        int cnt = 0;
        int p = 2;
        while (cnt < 64) begin
            bit isp = 1;
            for (int d = 2; d * d <= p; d++) if (p % d == 0) isp = 0;
            if (isp) begin primes[cnt] = p; cnt++; end
            p++;
        end
        for (int i = 0; i < 64; i++) begin
            real c, f;
            c = real'(primes[i]) ** (1.0 / 3.0);
            c = c - (c * c * c - real'(primes[i])) / (3.0 * c * c);
            f = $floor((c - $floor(c)) * 4294967296.0);
            kt[i] = 32'(longint'(f));
        end
        for (int i = 0; i < 8; i++) begin
            real s, f;
            s = $sqrt(real'(primes[i]));
            f = $floor((s - $floor(s)) * 4294967296.0);
            ivt[i] = 32'(longint'(f));
        end
    endtask

    function automatic logic [255:0] ref_hash(input logic [511:0] blk, input logic [255:0] chain, input bit first);
        logic [31:0] w [64];
        logic [31:0] h [8];
        logic [31:0] v [8];
        logic [31:0] t1, t2, s0, s1;
        logic [255:0] r;
        for (int i = 0; i < 8; i++) h[i] = first ? ivt[i] : chain[255-32*i -: 32];
        for (int t = 0; t < 16; t++) w[t] = blk[511-32*t -: 32];
        for (int t = 16; t < 64; t++) begin
            s0 = rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3);
            s1 = rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10);
            w[t] = s1 + w[t-7] + s0 + w[t-16];
        end
        for (int i = 0; i < 8; i++) v[i] = h[i];
        for (int t = 0; t < 64; t++) begin
            t1 = v[7] + (rr(v[4], 6) ^ rr(v[4], 11) ^ rr(v[4], 25))
               + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[t] + w[t];
            t2 = (rr(v[0], 2) ^ rr(v[0], 13) ^ rr(v[0], 22))
               + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
            for (int j = 7; j > 0; j--) v[j] = v[j-1];
            v[4] = v[4] + t1;
            v[0] = t1 + t2;
        end
        for (int i = 0; i < 8; i++) r[255-32*i -: 32] = h[i] + v[i];
        return r;
    endfunction

    function automatic logic [511:0] rnd_block();
        logic [511:0] b;
        for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom();
        return b;
    endfunction

    // disturb=1: stray start mid-run (R6) and scrambled inputs (R9)
    task automatic run_blk(input logic [511:0] blk, input logic [255:0] chain, input bit first,
                           input bit disturb, input string tag, output logic [255:0] dig);
        logic [255:0] exp;
        exp = ref_hash(blk, chain, first);
        @(negedge clk);
        block_i = blk; chain_i = chain; first_i = first; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(ready_o == 1'b0, "R8 ready low after accepted start", 256'(ready_o), 256'd0);
        if (disturb) begin
            block_i = rnd_block(); chain_i = {rnd_block()}[255:0]; first_i = ~first;
        end
        for (int c = 1; c <= 64; c++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = (disturb && (c == 30 || c == 31));
            if (c == 63) chk(ready_o == 1'b0, "R2 ready still low after edge 63", 256'(ready_o), 256'd0);
        end
        start_i = 1'b0;
        chk(ready_o == 1'b1, "R2 ready high after edge 64", 256'(ready_o), 256'd1);
        chk(hash_o == exp, tag, hash_o, exp);
        dig = hash_o;
    endtask

    localparam logic [511:0] BLK_ABC   = {32'h61626380, {14{32'h0}}, 32'h00000018};
    localparam logic [511:0] BLK_EMPTY = {32'h80000000, 480'h0};
    localparam logic [511:0] BLK_M1 = {32'h61626364, 32'h62636465, 32'h63646566, 32'h64656667,
                                       32'h65666768, 32'h66676869, 32'h6768696a, 32'h68696a6b,
                                       32'h696a6b6c, 32'h6a6b6c6d, 32'h6b6c6d6e, 32'h6c6d6e6f,
                                       32'h6d6e6f70, 32'h6e6f7071, 32'h80000000, 32'h00000000};
    localparam logic [511:0] BLK_M2 = {448'h0, 64'h1c0};
    localparam logic [255:0] DIG_ABC = 256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
    localparam logic [255:0] DIG_EMPTY = 256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
    localparam logic [255:0] DIG_M = 256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

    initial begin
        logic [255:0] d, d1, held;
        void'($urandom(32'd20240611));
        build_consts();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ready_o == 1'b0, "R1 ready after reset", 256'(ready_o), 256'd0);
        chk(hash_o == '0, "R1 hash after reset", hash_o, 256'd0);
        rst = 1'b0;

        run_blk(BLK_ABC, '0, 1'b1, 1'b0, "R3 abc digest", d);
        chk(d == DIG_ABC, "R3 R5 abc known vector", d, DIG_ABC);

        // R7: hold in done with junk inputs, no start
        held = hash_o;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            block_i = rnd_block(); chain_i = {rnd_block()}[255:0]; first_i = $urandom_range(0, 1);
        end
        @(negedge clk);
        chk(ready_o == 1'b1, "R7 ready held", 256'(ready_o), 256'd1);
        chk(hash_o == held, "R7 hash held", hash_o, held);

        run_blk(BLK_EMPTY, {rnd_block()}[255:0], 1'b1, 1'b0, "R3 empty digest", d);
        chk(d == DIG_EMPTY, "R3 empty known vector", d, DIG_EMPTY);

        run_blk(BLK_M1, '0, 1'b1, 1'b0, "R4 first of two", d1);
        run_blk(BLK_M2, d1, 1'b0, 1'b0, "R4 chained second", d);
        chk(d == DIG_M, "R4 R5 two-block known vector", d, DIG_M);

        run_blk(BLK_ABC, '0, 1'b1, 1'b1, "R6 R9 disturbed abc run", d);
        chk(d == DIG_ABC, "R6 R9 abc after disturbance", d, DIG_ABC);
        run_blk(BLK_M2, d1, 1'b0, 1'b1, "R6 R9 disturbed chained run", d);
        chk(d == DIG_M, "R9 chained after disturbance", d, DIG_M);

        for (int i = 0; i < 8; i++) begin
            logic [511:0] b;
            b = rnd_block();
            run_blk(b, d, (i % 3 == 0), (i % 4 == 3), "R5 random block", d);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule